// File: doc/BRIEF.md
# Multi-Mode Backplane Bus Arbiter

This block is the bus arbiter of the slot-one system controller on a VMEbus-style backplane. It watches four active-low bus request lines and the active-low bus-busy line. It drives one active-high grant output per request level, plus a bus-clear request. The grant outputs stand for the start of each level's grant daisy chain. Passing a grant from board to board is left to the chain, so relative priority between boards on the same level comes only from slot position.

A two-bit mode input picks the arbitration policy at run time:

- Single level: only the top request line is served.
- Fixed priority: level 3 is highest and level 0 lowest. A higher request that arrives during an ownership raises bus-clear.
- Rotating priority: the ranking shifts after each ownership so that the level just below the last owner comes first.

A timeout input, counted in clock cycles, withdraws a grant that no board takes up.

Top module: `vme_arbiter`

## Requirements
- R1: With `mode_i` = 0 (single level) or 3 (treated as single level), only request line 3 is considered, and only `bgnt_o[3]` is ever raised; requests on lines 0 to 2 cause no grant.
- R2: At most one bit of `bgnt_o` is high in any cycle.
- R3: A grant is decided only on a clock edge where `bbsy_ni` is high and an eligible request is present. The grant bit is high from that edge onward, and no grant is decided while `bbsy_ni` is low.
- R4: With `mode_i` = 1 (fixed priority), the highest-numbered active request wins: level 3 beats 2, 2 beats 1, and 1 beats 0.
- R5: A grant stays high until an edge samples `bbsy_ni` low; it drops at that edge, and the granted level becomes the owner. If the take-up and the timeout expiry fall on the same edge, the take-up wins.
- R6: If `bbsy_ni` stays high, a grant is withdrawn after max(`timeout_i`,1) cycles of being high. Arbitration then restarts from idle, so a new grant can appear one cycle after the withdrawal.
- R7: With `mode_i` = 1, while the owner holds `bbsy_ni` low, any request on a level above the owner's raises `bclr_o` one edge later. `bclr_o` then stays high until the edge that samples `bbsy_ni` high, and drops at that edge.
- R8: `bclr_o` never rises while `mode_i` is 0, 2 or 3.
- R9: With `mode_i` = 2 (rotating), levels rank downward cyclically from a top level. The top level is 3 after reset, and after each take-up it becomes the owner's level minus one (mod 4). This update happens in every mode.
- R10: While `rst_ni` is low, all of `bgnt_o` and `bclr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbiter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Policy: 0 single, 1 fixed priority, 2 rotating, 3 single |
| timeout_i | input | 8 | Grant take-up limit in clock cycles (0 acts as 1) |
| breq_ni | input | 4 | Bus request per level, active low |
| bbsy_ni | input | 1 | Bus busy, active low |
| bgnt_o | output | 4 | Grant per level, active high, one-hot or zero |
| bclr_o | output | 1 | Bus-clear request to the current owner |

## Verification
The take-up of a grant and the expiry of its timeout can land on the same edge. The bench provokes this with a three-cycle limit by pulling `bbsy_ni` low exactly in the third grant cycle. It then expects the grant to drop into ownership, not a withdrawal: the arbiter must hold off regranting while busy, and bus-clear must react to a later higher request. Random phases in every mode toggle requests and bus-busy freely, so both events collide often, and a behavioural per-cycle model judges each cycle.

// File: rtl/vme_arb_pkg.sv
package vme_arb_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_PRIO   = 2'd1,
    MODE_ROUND  = 2'd2,
    MODE_RSVD   = 2'd3
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick
  import vme_arb_pkg::*;
#(
  parameter int N_LVL = 4,
  localparam int LW = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] req_i,
  input  arb_mode_e        mode_i,
  input  logic [LW-1:0]    top_i,
  output logic             valid_o,
  output logic [LW-1:0]    idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    unique case (mode_i)
      MODE_PRIO: begin
        // ascending scan: highest level wins
        for (int i = 0; i < N_LVL; i++) begin
          if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = LW'(i);
          end
        end
      end
      MODE_ROUND: begin
        // scan from lowest rank to top so the top-most requester is kept
        for (int k = N_LVL - 1; k >= 0; k--) begin
          int p;
          p = (int'(top_i) + N_LVL - k) % N_LVL;
          if (req_i[p]) begin
            valid_o = 1'b1;
            idx_o   = LW'(p);
          end
        end
      end
      default: begin
        if (req_i[N_LVL-1]) begin
          valid_o = 1'b1;
          idx_o   = LW'(N_LVL - 1);
        end
      end
    endcase
  end
endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  // limit 0 behaves as 1
  assign expire_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/arb_hi_req.sv
module arb_hi_req #(
  parameter int N_LVL = 4,
  localparam int LW = $clog2(N_LVL)
) (
  input  logic [N_LVL-1:0] req_i,
  input  logic [LW-1:0]    owner_i,
  output logic             hi_o
);
  logic [N_LVL-1:0] above;

  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign above[g] = req_i[g] && (LW'(g) > owner_i);
  end

  assign hi_o = |above;
endmodule

// File: rtl/vme_arbiter.sv
module vme_arbiter
  import vme_arb_pkg::*;
#(
  parameter int N_LVL = 4,
  parameter int TMO_W = 8,
  localparam int LW = $clog2(N_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [N_LVL-1:0] breq_ni,
  input  logic             bbsy_ni,
  output logic [N_LVL-1:0] bgnt_o,
  output logic             bclr_o
);
  arb_state_e       state_q;
  logic [LW-1:0]    gnt_idx_q, owner_q, top_q;
  logic             bclr_q;
  logic [N_LVL-1:0] req;
  logic             busy, pick_vld, tmo_exp, hi_req;
  logic [LW-1:0]    pick_idx;
  arb_mode_e        mode;

  assign req  = ~breq_ni;
  assign busy = ~bbsy_ni;
  assign mode = arb_mode_e'(mode_i);

  arb_pick #(.N_LVL(N_LVL)) u_pick (
    .req_i   (req),
    .mode_i  (mode),
    .top_i   (top_q),
    .valid_o (pick_vld),
    .idx_o   (pick_idx)
  );

  arb_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q != ST_GRANT),
    .en_i     (state_q == ST_GRANT),
    .limit_i  (timeout_i),
    .expire_o (tmo_exp)
  );

  arb_hi_req #(.N_LVL(N_LVL)) u_hi (
    .req_i   (req),
    .owner_i (owner_q),
    .hi_o    (hi_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      gnt_idx_q <= '0;
      owner_q   <= '0;
      top_q     <= LW'(N_LVL - 1);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!busy && pick_vld) begin
            state_q   <= ST_GRANT;
            gnt_idx_q <= pick_idx;
          end
        end
        ST_GRANT: begin
          // take-up has precedence over expiry
          if (busy) begin
            state_q <= ST_BUSY;
            owner_q <= gnt_idx_q;
            top_q   <= (gnt_idx_q == '0) ? LW'(N_LVL - 1) : LW'(gnt_idx_q - 1'b1);
          end else if (tmo_exp) begin
            state_q <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (!busy) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclr_q <= 1'b0;
    else         bclr_q <= (state_q == ST_BUSY) && busy &&
                           (bclr_q || (mode == MODE_PRIO && hi_req));
  end

  always_comb begin
    bgnt_o = '0;
    if (state_q == ST_GRANT) bgnt_o[gnt_idx_q] = 1'b1;
  end

  assign bclr_o = bclr_q;
endmodule

// File: rtl/vme_arbiter_chk.sv
module vme_arbiter_chk
  import vme_arb_pkg::*;
#(
  parameter int N_LVL = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [N_LVL-1:0] breq_ni,
  input logic             bbsy_ni,
  input logic [N_LVL-1:0] bgnt_o,
  input logic             bclr_o
);
  logic [N_LVL-1:0] top_only;
  assign top_only = {1'b1, {(N_LVL-1){1'b0}}};

  a_r2_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bgnt_o));

  a_r1_single_top_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|bgnt_o) && ($past(mode_i) == MODE_SINGLE || $past(mode_i) == MODE_RSVD))
      |-> bgnt_o == top_only);

  a_r3_grant_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|bgnt_o) |-> ($past(bbsy_ni) && !$past(&breq_ni)));

  a_r5_drop_on_takeup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|bgnt_o) && !bbsy_ni) |=> !(|bgnt_o));

  a_r7_bclr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclr_o && !bbsy_ni) |=> bclr_o);

  a_r7_bclr_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bbsy_ni |=> !bclr_o);

  a_r8_bclr_prio_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclr_o) |-> $past(mode_i) == MODE_PRIO);
endmodule

bind vme_arbiter vme_arbiter_chk #(.N_LVL(N_LVL)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .breq_ni (breq_ni),
  .bbsy_ni (bbsy_ni),
  .bgnt_o  (bgnt_o),
  .bclr_o  (bclr_o)
);

// File: tb/test_vme_arbiter.sv
`timescale 1ns/1ps
module test_vme_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] tmo = 8'd3;
  logic [3:0] breq = 4'hf;
  logic       bbsy = 1'b1;
  logic [3:0] bgnt;
  logic       bclr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  vme_arbiter i_vme_arbiter (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .timeout_i (tmo),
    .breq_ni   (breq),
    .bbsy_ni   (bbsy),
    .bgnt_o    (bgnt),
    .bclr_o    (bclr)
  );

  // behavioural reference: 0 idle, 1 granting, 2 owned
  int m_st = 0, m_w = 0, m_cnt = 0, m_owner = 0, m_top = 3;
  bit m_bclr = 0;
  logic [3:0] m_gnt;
  assign m_gnt = (m_st == 1) ? 4'(1 << m_w) : 4'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_cnt = 0; m_owner = 0; m_top = 3; m_bclr = 0;
    end else begin
      logic [3:0] rq;
      bit bz;
      int lim;
      rq = ~breq; bz = !bbsy; lim = (tmo == 0) ? 1 : int'(tmo);
      case (m_st)
        0: if (!bz) begin
          int w;
          w = -1;
          if (mode == 2'd1) begin
            for (int i = 3; i >= 0; i--) if (w < 0 && rq[i]) w = i;
          end else if (mode == 2'd2) begin
            for (int k = 0; k < 4; k++) if (w < 0 && rq[(m_top - k + 4) % 4]) w = (m_top - k + 4) % 4;
          end else if (rq[3]) w = 3;
          if (w >= 0) begin m_st = 1; m_w = w; m_cnt = 0; end
        end
        1: if (bz) begin
          m_st = 2; m_owner = m_w; m_top = (m_w + 3) % 4;
        end else if (m_cnt + 1 >= lim) m_st = 0;
        else m_cnt++;
        default: if (!bz) begin
          m_st = 0; m_bclr = 0;
        end else if (mode == 2'd1) begin
          for (int i = 0; i < 4; i++) if (rq[i] && i > m_owner) m_bclr = 1;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    string t;
    t = (mode == 2'd1) ? "R4" : (mode == 2'd2) ? "R9" : "R1";
    chk(bgnt == m_gnt, {t, " grant vs model"}, bgnt, m_gnt);
    chk(bclr == m_bclr, "R7 bclr vs model", bclr, m_bclr);
    chk($countones(bgnt) <= 1, "R2 one-hot grant", bgnt, 0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_gnt(input int lim);
    for (int i = 0; i < lim && bgnt == 4'h0; i++) step(1);
  endtask

  task automatic drain();
    breq = 4'hf; bbsy = 1'b1; step(20);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    step(3);
    chk(bgnt == 4'h0, "R10 reset grant", bgnt, 0);
    chk(bclr == 1'b0, "R10 reset bclr", bclr, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    step(2);

    // R1: lines 0..2 ignored in single level
    mode = 2'd0; breq = 4'b1000; step(6);
    chk(bgnt == 4'h0, "R1 low lines ignored", bgnt, 0);
    mode = 2'd3; step(4);
    chk(bgnt == 4'h0, "R1 reserved mode as single", bgnt, 0);
    mode = 2'd0; drain();

    // R6: timeout withdrawal after exactly 3 cycles, then restart
    tmo = 8'd3; breq = 4'b0111; wait_gnt(10);
    begin
      int n;
      n = 0;
      while (bgnt[3] && n < 20) begin n++; step(1); end
      chk(n == 3, "R6 grant length", n, 3);
    end
    chk(bgnt == 4'h0, "R6 gap after withdrawal", bgnt, 0);
    step(1);
    chk(bgnt == 4'b1000, "R6 regrant after restart", bgnt, 4'b1000);
    drain();

    // R5: take-up on the same edge as expiry
    breq = 4'b0111; wait_gnt(10);
    step(2);
    chk(bgnt == 4'b1000, "R5 grant still held", bgnt, 4'b1000);
    bbsy = 1'b0; step(1);
    chk(bgnt == 4'h0, "R5 drop on take-up", bgnt, 0);
    step(4);
    chk(bgnt == 4'h0, "R3 no grant while busy", bgnt, 0);
    drain();

    // R4: fixed priority order
    mode = 2'd1; breq = 4'b1000; wait_gnt(10);
    chk(bgnt == 4'b0100, "R4 level 2 beats 1 and 0", bgnt, 4'b0100);
    drain();

    // R7: bus-clear on higher request while owned
    breq = 4'b1101; wait_gnt(10);
    chk(bgnt == 4'b0010, "R4 lone level 1", bgnt, 4'b0010);
    bbsy = 1'b0; breq = 4'hf; step(2);
    chk(bclr == 1'b0, "R7 no bclr without higher", bclr, 0);
    breq = 4'b1110; step(2);
    chk(bclr == 1'b0, "R7 lower request ignored", bclr, 0);
    breq = 4'b0111; step(1);
    chk(bclr == 1'b1, "R7 bclr raised", bclr, 1);
    breq = 4'hf; step(3);
    chk(bclr == 1'b1, "R7 bclr held", bclr, 1);
    bbsy = 1'b1; step(1);
    chk(bclr == 1'b0, "R7 bclr released", bclr, 0);
    drain();

    // R9 and R8: rotation and no bus-clear
    mode = 2'd2; breq = 4'b1011; wait_gnt(10);
    chk(bgnt == 4'b0100, "R9 lone level 2", bgnt, 4'b0100);
    bbsy = 1'b0; breq = 4'b0111; step(3);
    chk(bclr == 1'b0, "R8 no bclr in rotating", bclr, 0);
    breq = 4'b0000; bbsy = 1'b1; step(1); wait_gnt(10);
    chk(bgnt == 4'b0010, "R9 level 1 first after 2", bgnt, 4'b0010);
    bbsy = 1'b0; breq = 4'hf; step(2);
    breq = 4'b0000; bbsy = 1'b1; step(1); wait_gnt(10);
    chk(bgnt == 4'b0001, "R9 level 0 first after 1", bgnt, 4'b0001);
    drain();

    // random phases judged by the model, every mode
    for (int ph = 0; ph < 8; ph++) begin
      mode = 2'(ph % 4);
      tmo = 8'($urandom_range(0, 6));
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(0, 3) == 0) breq = 4'($urandom);
        if ($urandom_range(0, 5) == 0) bbsy = ~bbsy;
        step(1);
      end
    end
    drain();
    finish_run();
  end
endmodule